// File: doc/BRIEF.md
# Mode-banked general register file

This block is the general register file of a small 32-bit RISC core. Software names sixteen registers with a 4-bit index. The physical register that an index reaches depends on the processor mode held in the current status register. The low eight registers are one set that every mode shares. The fast-interrupt modes swap in a private upper set. The other exception modes swap in only their stack and link registers. Each exception mode also keeps its own saved status register. Both the legacy 26-bit modes and the 32-bit modes are supported. In a 26-bit mode, index 15 reads as a packed word that holds the flags, the interrupt masks, the word address of the program counter and the low mode bits.

The file has two read ports and one write port. A user-bank input sends every access in that cycle to the User-mode registers. An exception-entry strobe saves the status and switches mode. A return strobe writes the program counter and restores the status. A status-write port loads either the current or the saved status register. All updates take effect at the rising clock edge. Read data is registered, so it appears one cycle after the index is presented.

Top module: `mode_banked_regfile`

## Requirements
- R1: The mode field (status bits 4:0) picks the bank as follows. 00000 and 10000 select User. 00001 and 10001 select FIQ. 00010 and 10010 select IRQ. 00011 and 10011 select SVC. 10111 selects Abort and 11011 selects Undefined. Any other code banks as User, and its saved-status view shows the current status. A mode is 26-bit when bit 4 is 0.
- R2: Indices 0 to 7 reach one physical set in every mode.
- R3: The FIQ and FIQ26 modes share a private set for indices 8 to 14. Every other mode uses the common set for indices 8 to 12.
- R4: SVC, IRQ, Abort and Undefined each have their own indices 13 and 14. SVC26 uses the SVC pair, IRQ26 uses the IRQ pair, and User and User26 use the common pair.
- R5: Reading index 15 in a 32-bit mode returns the PC. In a 26-bit mode it returns {N,Z,C,V (31:28), I (27), F (26), PC[25:2], mode[1:0]}.
- R6: While usr_bank is high, reads and writes on every port reach the User-mode registers, whatever the current mode.
- R7: Read data appears on the cycle after the index is presented. A read of a register that is written in the same cycle returns the old value.
- R8: Exception entry to a mode that has a saved status register does three things in one cycle. It copies the current status into that mode's saved status. It loads the new mode and sets I (bit 7). For an FIQ-bank target it also sets F (bit 6). An entry to a User-bank target is ignored. A general write in the entry cycle uses the bank of the old mode.
- R9: In a 32-bit mode, a return writes ret_data with bits 1:0 cleared into the PC. It also copies the saved-status view into the current status. An exception entry in the same cycle cancels the return.
- R10: In a 26-bit mode, a return replaces PC[25:2] with ret_data[25:2]. It loads the flags from ret_data[31:28], I from ret_data[27] and F from ret_data[26]. It loads the mode as {000, ret_data[1:0]}.
- R11: A status write keeps only bits 31:28, 7:6 and 4:0, and clears all other bits. A write to the saved status register in a User-bank mode is ignored.
- R12: After reset, both read outputs are 0, the current status is 0x000000D3, the PC is 0 and every saved status register is 0.
- R13: A write to index 15 in a 32-bit mode loads the PC with bits 1:0 cleared. In a 26-bit mode it changes only PC[25:2] and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data, one cycle later |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data, one cycle later |
| usr_bank | input | 1 | Send this cycle's reads and writes to the User registers |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| exc_take | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode of the entry |
| ret_take | input | 1 | Status-restoring return strobe |
| ret_data | input | 32 | Return PC value (or packed word in a 26-bit mode) |
| psr_wr_en | input | 1 | Status register write strobe |
| psr_wr_saved | input | 1 | Select the saved (1) or the current (0) status register |
| psr_wr_data | input | 32 | Status write data |
| cpsr_o | output | 32 | Current status register |
| spsr_o | output | 32 | Saved status of the current mode, or the current status in a User-bank mode |

## Verification
The bench drives an exception entry in the same cycle as a general write to index 14, made while still in User mode. It then reads index 14 in the new IRQ mode and again through the user bank. The write must land only in the User copy, while the IRQ copy keeps its earlier value and the saved status holds the pre-entry word. A second collision is a read and a write of the same register in one cycle. The queued expectation there is the old value, and the new value must appear only on the next read.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam int unsigned NUM_BANKS = 6;
  localparam logic [31:0] PSR_KEEP  = 32'hF000_00DF;
  localparam logic [31:0] PSR_RESET = 32'h0000_00D3;
  localparam int unsigned PSR_I_BIT = 7;
  localparam int unsigned PSR_F_BIT = 6;

  function automatic bank_e mode_bank(input logic [4:0] m);
    case (m)
      5'b00001, 5'b10001: mode_bank = BK_FIQ;
      5'b00010, 5'b10010: mode_bank = BK_IRQ;
      5'b00011, 5'b10011: mode_bank = BK_SVC;
      5'b10111:           mode_bank = BK_ABT;
      5'b11011:           mode_bank = BK_UND;
      default:            mode_bank = BK_USR;
    endcase
  endfunction

endpackage

// File: rtl/mbrf_bank_map.sv
module mbrf_bank_map
  import mbrf_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int SHARED_N = 8,
  parameter int UPPER_N  = 5,
  parameter int PHYS_W   = 5
) (
  input  bank_e              bank,
  input  logic [IDX_W-1:0]   idx,
  output logic [PHYS_W-1:0]  phys
);
  localparam int FIQ_BASE  = SHARED_N + UPPER_N;
  localparam int PAIR_BASE = FIQ_BASE + UPPER_N;
  localparam int PAIR_IDX  = SHARED_N + UPPER_N;

  always_comb begin
    int i;
    i = int'(idx);
    if (i < SHARED_N)
      phys = PHYS_W'(i);
    else if (i < PAIR_IDX)
      phys = (bank == BK_FIQ) ? PHYS_W'(FIQ_BASE + i - SHARED_N) : PHYS_W'(i);
    else if (i < PAIR_IDX + 2)
      phys = PHYS_W'(PAIR_BASE + 2 * int'(bank) + i - PAIR_IDX);
    else
      phys = '0;
  end
endmodule

// File: rtl/mbrf_gpr_store.sv
module mbrf_gpr_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  input  logic [ADDR_W-1:0] rb,
  output logic [DATA_W-1:0] qa,
  output logic [DATA_W-1:0] qb
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qa <= '0;
      qb <= '0;
    end else begin
      qa <= mem[ra];
      qb <= mem[rb];
    end
  end
endmodule

// File: rtl/mbrf_psr_unit.sv
module mbrf_psr_unit
  import mbrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        exc_take,
  input  logic [4:0]  exc_mode,
  input  logic        ret_take,
  input  logic [31:0] ret_data,
  input  logic        psr_wr_en,
  input  logic        psr_wr_saved,
  input  logic [31:0] psr_wr_data,
  output logic [31:0] cpsr,
  output logic [31:0] spsr_view,
  output bank_e       cur_bank,
  output logic        mode26
);
  logic [31:0] spsr [NUM_BANKS];
  bank_e       tgt_bank;
  logic        exc_ok;

  assign cur_bank  = mode_bank(cpsr[4:0]);
  assign tgt_bank  = mode_bank(exc_mode);
  assign exc_ok    = exc_take && (tgt_bank != BK_USR);
  assign mode26    = ~cpsr[4];
  assign spsr_view = (cur_bank == BK_USR) ? cpsr : spsr[cur_bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      cpsr <= PSR_RESET;
      for (int b = 0; b < NUM_BANKS; b++) spsr[b] <= '0;
    end else if (exc_ok) begin
      spsr[tgt_bank]   <= cpsr;
      cpsr[4:0]        <= exc_mode;
      cpsr[PSR_I_BIT]  <= 1'b1;
      if (tgt_bank == BK_FIQ) cpsr[PSR_F_BIT] <= 1'b1;
    end else if (ret_take && !exc_take) begin
      if (mode26)
        cpsr <= {ret_data[31:28], 20'b0, ret_data[27], ret_data[26], 1'b0, 3'b000, ret_data[1:0]};
      else
        cpsr <= spsr_view;
    end else if (psr_wr_en) begin
      if (!psr_wr_saved)
        cpsr <= psr_wr_data & PSR_KEEP;
      else if (cur_bank != BK_USR)
        spsr[cur_bank] <= psr_wr_data & PSR_KEEP;
    end
  end

  AST_ENTRY_SAVES_STATUS: assert property (@(posedge clk) disable iff (rst)
    exc_ok |=> spsr_view == $past(cpsr)) else $error("entry save"); // R8

  AST_ENTRY_MODE_MASK: assert property (@(posedge clk) disable iff (rst)
    exc_ok |=> (cpsr[4:0] == $past(exc_mode)) && cpsr[PSR_I_BIT]) else $error("entry mode"); // R8

  AST_FIQ_ENTRY_F: assert property (@(posedge clk) disable iff (rst)
    (exc_ok && tgt_bank == BK_FIQ) |=> cpsr[PSR_F_BIT]) else $error("fiq F"); // R8

  AST_RET32_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (ret_take && !exc_take && !mode26) |=> cpsr == $past(spsr_view)) else $error("ret32"); // R9

  AST_USER_NO_SAVED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (psr_wr_en && psr_wr_saved && !exc_take && !ret_take && cur_bank == BK_USR) |=> $stable(cpsr))
    else $error("user saved write"); // R11
endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
  import mbrf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter int SHARED_N = 8,
  parameter int UPPER_N  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              usr_bank,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              exc_take,
  input  logic [4:0]        exc_mode,
  input  logic              ret_take,
  input  logic [DATA_W-1:0] ret_data,
  input  logic              psr_wr_en,
  input  logic              psr_wr_saved,
  input  logic [DATA_W-1:0] psr_wr_data,
  output logic [DATA_W-1:0] cpsr_o,
  output logic [DATA_W-1:0] spsr_o
);
  localparam int DEPTH   = SHARED_N + 2 * UPPER_N + 2 * NUM_BANKS;
  localparam int PHYS_W  = $clog2(DEPTH);
  localparam int NPORTS  = 3;
  localparam logic [IDX_W-1:0] PC_IDX = '1;

  logic [31:0] cpsr, spsr_view;
  bank_e       cur_bank, acc_bank;
  logic        mode26;
  logic [DATA_W-1:0] pc, r15_view, r15_q, ram_a, ram_b;
  logic        sel15_a, sel15_b;
  logic [IDX_W-1:0]  port_idx  [NPORTS];
  logic [PHYS_W-1:0] port_phys [NPORTS];
  logic        ret_eff, pc_wr;
  logic [DATA_W-1:0] pc_src;

  mbrf_psr_unit u_psr (
    .clk, .rst, .exc_take, .exc_mode, .ret_take, .ret_data,
    .psr_wr_en, .psr_wr_saved, .psr_wr_data,
    .cpsr, .spsr_view, .cur_bank, .mode26
  );

  assign acc_bank    = usr_bank ? BK_USR : cur_bank;
  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign port_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORTS; p++) begin : g_map
    mbrf_bank_map #(.IDX_W(IDX_W), .SHARED_N(SHARED_N), .UPPER_N(UPPER_N), .PHYS_W(PHYS_W)) u_map (
      .bank (acc_bank),
      .idx  (port_idx[p]),
      .phys (port_phys[p])
    );
  end

  mbrf_gpr_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(PHYS_W)) u_store (
    .clk, .rst,
    .we (wr_en && wr_idx != PC_IDX),
    .wa (port_phys[2]),
    .wd (wr_data),
    .ra (port_phys[0]),
    .rb (port_phys[1]),
    .qa (ram_a),
    .qb (ram_b)
  );

  assign ret_eff = ret_take && !exc_take;
  assign pc_wr   = ret_eff || (wr_en && wr_idx == PC_IDX);
  assign pc_src  = ret_eff ? ret_data : wr_data;

  always_ff @(posedge clk) begin
    if (rst)
      pc <= '0;
    else if (pc_wr) begin
      if (mode26) pc[25:2] <= pc_src[25:2];
      else        pc <= {pc_src[DATA_W-1:2], 2'b00};
    end
  end

  assign r15_view = mode26 ? {cpsr[31:28], cpsr[PSR_I_BIT], cpsr[PSR_F_BIT], pc[25:2], cpsr[1:0]} : pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel15_a <= 1'b0;
      sel15_b <= 1'b0;
      r15_q   <= '0;
    end else begin
      sel15_a <= (rd_a_idx == PC_IDX);
      sel15_b <= (rd_b_idx == PC_IDX);
      r15_q   <= r15_view;
    end
  end

  assign rd_a_data = sel15_a ? r15_q : ram_a;
  assign rd_b_data = sel15_b ? r15_q : ram_b;
  assign cpsr_o    = cpsr;
  assign spsr_o    = spsr_view;

  AST_PC32_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == PC_IDX && !ret_eff && !mode26) |=> pc == {$past(wr_data[DATA_W-1:2]), 2'b00})
    else $error("pc32 write"); // R13

  AST_PC26_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && mode26) |=> pc[DATA_W-1:26] == $past(pc[DATA_W-1:26])) else $error("pc26 upper"); // R10

  AST_PC26_WRITE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == PC_IDX && mode26 && !ret_take && !exc_take && !psr_wr_en) |=> $stable(cpsr_o))
    else $error("pc26 status"); // R13
endmodule

// File: tb/test_mode_banked_regfile.sv
module test_mode_banked_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, ret_data = '0, psr_wr_data = '0;
  logic        usr_bank = 0, wr_en = 0, exc_take = 0, ret_take = 0, psr_wr_en = 0, psr_wr_saved = 0;
  logic [4:0]  exc_mode = '0;
  logic [31:0] cpsr_o, spsr_o;

  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { int due; bit port; logic [31:0] exp; string req; } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mode_banked_regfile i_mode_banked_regfile (
    .clk, .rst, .rd_a_idx, .rd_a_data, .rd_b_idx, .rd_b_data, .usr_bank,
    .wr_en, .wr_idx, .wr_data, .exc_take, .exc_mode, .ret_take, .ret_data,
    .psr_wr_en, .psr_wr_saved, .psr_wr_data, .cpsr_o, .spsr_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FIAL-free mismatch marker"); 
    end
  endtask

  // monitor: pops queued read expectations as the data appears
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = it.port ? rd_b_data : rd_a_data;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: read port %0d got %h expected %h", it.req, it.port, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    wr_en = 0; exc_take = 0; ret_take = 0; psr_wr_en = 0; psr_wr_saved = 0; usr_bank = 0;
  endtask

  task automatic rd(input bit port, input logic [3:0] idx, input logic [31:0] exp, input string req);
    if (port) rd_b_idx = idx; else rd_a_idx = idx;
    exp_q.push_back('{cyc + 1, port, exp, req});
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    wr_en = 1; wr_idx = idx; wr_data = d;
  endtask

  task automatic setpsr(input bit saved, input logic [31:0] d);
    psr_wr_en = 1; psr_wr_saved = saved; psr_wr_data = d; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    chk("R12", rd_a_data, 32'h0); chk("R12", rd_b_data, 32'h0);
    chk("R12", cpsr_o, 32'h0000_00D3); chk("R12", spsr_o, 32'h0);
    rd(0, 4'd15, 32'h0, "R12"); tick();

    // fill banks
    setpsr(0, 32'h10);
    for (int i = 0; i < 15; i++) begin wr(4'(i), 32'hA000_0000 + i); tick(); end
    setpsr(0, 32'h11);
    for (int i = 8; i < 15; i++) begin wr(4'(i), 32'hF000_0000 + i); tick(); end
    wr(4'd0, 32'h0000_F0F0); tick();
    setpsr(0, 32'h12); wr(4'd13, 32'h1200_000D); tick(); wr(4'd14, 32'h1200_000E); tick();
    setpsr(0, 32'h13); wr(4'd13, 32'h1300_000D); tick(); wr(4'd14, 32'h1300_000E); tick();
    setpsr(0, 32'h17); wr(4'd13, 32'h1700_000D); tick(); wr(4'd14, 32'h1700_000E); tick();
    setpsr(0, 32'h1B); wr(4'd13, 32'h1B00_000D); tick(); wr(4'd14, 32'h1B00_000E); tick();

    rd(0, 4'd0, 32'h0000_F0F0, "R2"); rd(1, 4'd8, 32'hA000_0008, "R3"); tick();
    rd(0, 4'd13, 32'h1B00_000D, "R4"); rd(1, 4'd5, 32'hA000_0005, "R2"); tick();
    setpsr(0, 32'h17); rd(0, 4'd14, 32'h1700_000E, "R4"); tick();
    setpsr(0, 32'h01); rd(0, 4'd9, 32'hF000_0009, "R3"); rd(1, 4'd14, 32'hF000_000E, "R3"); tick();
    setpsr(0, 32'h02); rd(0, 4'd13, 32'h1200_000D, "R4"); rd(1, 4'd12, 32'hA000_000C, "R3"); tick();
    setpsr(0, 32'h03); rd(0, 4'd14, 32'h1300_000E, "R4"); tick();
    setpsr(0, 32'h00); rd(0, 4'd13, 32'hA000_000D, "R4"); tick();
    // R1 unknown code banks as User
    setpsr(0, 32'h15); rd(0, 4'd13, 32'hA000_000D, "R1"); rd(1, 4'd8, 32'hA000_0008, "R1"); tick();
    chk("R1", spsr_o, 32'h15);

    // R6 user-bank override
    setpsr(0, 32'h11);
    usr_bank = 1; rd(0, 4'd10, 32'hA000_000A, "R6"); tick();
    usr_bank = 1; wr(4'd11, 32'h0B0B_0B0B); tick();
    rd(0, 4'd11, 32'hF000_000B, "R6"); tick();
    usr_bank = 1; rd(0, 4'd11, 32'h0B0B_0B0B, "R6"); tick();

    // R7 read during write
    setpsr(0, 32'h10);
    wr(4'd3, 32'h0000_0033); rd(0, 4'd3, 32'hA000_0003, "R7"); tick();
    rd(0, 4'd3, 32'h0000_0033, "R7"); tick();

    // R13 / R5 program counter writes in both widths
    setpsr(0, 32'hD3); wr(4'd15, 32'h1234_5677); tick();
    rd(0, 4'd15, 32'h1234_5674, "R13"); tick();
    setpsr(0, 32'hA000_00C3); rd(0, 4'd15, 32'hAE34_5677, "R5"); tick();
    wr(4'd15, 32'hFFFF_FFFF); tick();
    chk("R13", cpsr_o, 32'hA000_00C3);
    rd(1, 4'd15, 32'hAFFF_FFFF, "R13"); tick();
    setpsr(0, 32'hD3); rd(0, 4'd15, 32'h13FF_FFFC, "R13"); tick();

    // R8 entry colliding with a write
    setpsr(0, 32'h6000_0010);
    exc_take = 1; exc_mode = 5'h12; wr(4'd14, 32'hDEAD_0001); tick();
    chk("R8", cpsr_o, 32'h6000_0092); chk("R8", spsr_o, 32'h6000_0010);
    rd(0, 4'd14, 32'h1200_000E, "R8"); tick();
    usr_bank = 1; rd(0, 4'd14, 32'hDEAD_0001, "R8"); tick();
    exc_take = 1; exc_mode = 5'h11; tick();
    chk("R8", cpsr_o, 32'h6000_00D1); chk("R8", spsr_o, 32'h6000_0092);
    exc_take = 1; exc_mode = 5'h10; tick();
    chk("R8", cpsr_o, 32'h6000_00D1);

    // R9 32-bit returns
    ret_take = 1; ret_data = 32'h0000_0403; tick();
    chk("R9", cpsr_o, 32'h6000_0092);
    rd(0, 4'd15, 32'h0000_0400, "R9"); tick();
    ret_take = 1; ret_data = 32'h0000_0404; tick();
    chk("R9", cpsr_o, 32'h6000_0010); chk("R9", spsr_o, 32'h6000_0010);

    // R11 status writes
    setpsr(1, 32'h1234_5678);
    chk("R11", cpsr_o, 32'h6000_0010); chk("R11", spsr_o, 32'h6000_0010);
    setpsr(0, 32'hD3); setpsr(1, 32'hFFFF_FFFF);
    chk("R11", spsr_o, 32'hF000_00DF);
    ret_take = 1; ret_data = 32'h0; tick();
    chk("R9", cpsr_o, 32'hF000_00DF); chk("R1", spsr_o, 32'hF000_00DF);
    rd(0, 4'd13, 32'hA000_000D, "R1"); tick();

    // R10 26-bit return
    setpsr(0, 32'hC3);
    ret_take = 1; ret_data = 32'h5C00_1002; tick();
    chk("R10", cpsr_o, 32'h5000_00C2);
    rd(0, 4'd15, 32'h5C00_1002, "R10"); tick();

    tick(); tick();
    chk("R7", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule